// File: doc/BRIEF.md
# Floating-Point Register Stack Push Unit

This block holds an eight-slot file of 80-bit extended-precision registers. The slots are addressed relative to a moving top-of-stack pointer, so stack register ST(i) lives in physical slot (TOP + i) mod 8. A load-push command takes its operand from one of two sources: an already converted 80-bit value on the command bus, or a stack register ST(i). A pop command drains the stack. Each slot carries a valid/empty tag. The block detects stack overflow and underflow and reports them through condition bit C1 and a stack-fault flag.

Commands use a single-cycle valid/ready handshake and complete in the clock edge that accepts them. A relative read port shows any ST(i) and its tag. With that port and the pointer output, the surrounding pipeline, or a bench, can see the whole stack.

Top module: `fpstk_unit`

## Requirements
- R1: After reset the top pointer is 0, every slot reads empty, C1 and the stack-fault flag are 0, and ready is 1 from the first clock edge after reset is released.
- R2: An accepted fault-free push with the external source (cmd_src_reg_i = 0) decrements the top pointer modulo 8. It writes cmd_data_i into the new ST(0) and tags that slot valid. Slots that were valid keep their values, now seen at index + 1.
- R3: With cmd_src_reg_i = 1 the pushed value is ST(cmd_src_idx_i), taken relative to the top pointer before the decrement. Pushing ST(0) therefore leaves the same value in ST(0) and ST(1).
- R4: A push is an overflow when the slot that would become the new ST(0) is already valid. An overflow sets C1 = 1 and the stack-fault flag to 1.
- R5: A push without overflow clears C1 to 0. Its stack-fault flag is 0 unless it is an underflow.
- R6: A register-source push whose source ST(i) is empty is an underflow. It sets the stack-fault flag to 1. C1 is 0 unless the push is also an overflow.
- R7: On a push fault with ia_mask_i = 1, the block pushes the indefinite quiet NaN (sign 1, exponent all ones, significand 0xC000000000000000) and decrements the pointer.
- R8: On a fault with ia_mask_i = 0, the top pointer, every tag and every register value stay unchanged.
- R9: An accepted pop marks ST(0) empty and increments the top pointer modulo 8, and clears C1. A pop of an empty ST(0) sets the stack-fault flag. That pop still proceeds when ia_mask_i = 1 and follows R8 when ia_mask_i = 0.
- R10: With cmd_valid_i low, no state changes: the pointer, the tags, the values, C1 and the stack-fault flag all hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_pop_i | input | 1 | 1 = pop, 0 = load-push |
| cmd_src_reg_i | input | 1 | Push source: 1 = ST(i), 0 = cmd_data_i |
| cmd_src_idx_i | input | 3 | Index i of the register source |
| cmd_data_i | input | 80 | External push value, already in 80-bit format |
| ia_mask_i | input | 1 | Invalid-operation mask |
| rd_idx_i | input | 3 | Relative read index |
| rd_data_o | output | 80 | Value of ST(rd_idx_i) |
| rd_valid_o | output | 1 | Tag of ST(rd_idx_i), 1 = valid |
| top_o | output | 3 | Top-of-stack pointer |
| c1_o | output | 1 | Condition bit C1 from the last accepted command |
| stack_fault_o | output | 1 | Stack fault from the last accepted command |

## Verification
The bench builds the block with its defaults: eight slots, a 15-bit exponent and a 64-bit significand. With eight slots, random push/pop sequences of a few thousand commands often fill the stack, empty it and wrap the pointer. This exercises overflow with both mask settings, empty-source underflow, ST(7) sources that alias the destination slot, and pops of an empty top. Directed sequences pin down duplication of ST(0), the exact indefinite encoding and idle cycles.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic {
    OP_PUSH = 1'b0,
    OP_POP  = 1'b1
  } fpstk_op_e;

  typedef struct packed {
    logic c1;
    logic fault;
  } fpstk_stat_t;
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_en_i,
  input  logic [PTR_W-1:0]  clr_idx_i,
  input  logic [PTR_W-1:0]  ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [PTR_W-1:0]  rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  output logic [DEPTH-1:0]  tags_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  tag_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     tag_q[g] <= 1'b0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))       tag_q[g] <= 1'b1;
      else if (clr_en_i && clr_idx_i == PTR_W'(g))     tag_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     data_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))       data_q[g] <= wr_data_i;
    end
  end

  assign ra_data_o = data_q[ra_idx_i];
  assign rb_data_o = data_q[rb_idx_i];
  assign tags_o    = tag_q;

  // R2: a written slot is tagged valid and holds the data
  a_r2_write_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> tag_q[$past(wr_idx_i)] && data_q[$past(wr_idx_i)] == $past(wr_data_i));
  // R9: a cleared slot reads empty
  a_r9_clear_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i && !wr_en_i |=> !tag_q[$past(clr_idx_i)]);
  a_r9_no_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && clr_en_i));
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 80,
  parameter int EXP_W  = 15,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int MAN_W = DATA_W - EXP_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  fpstk_op_e         op_i,
  input  logic              src_reg_i,
  input  logic [PTR_W-1:0]  src_idx_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              ia_mask_i,
  input  logic [DEPTH-1:0]  tags_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [PTR_W-1:0]  top_o,
  output logic [PTR_W-1:0]  src_phys_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              clr_en_o,
  output logic [PTR_W-1:0]  clr_idx_o,
  output fpstk_stat_t       stat_o
);
  localparam logic [DATA_W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  logic [PTR_W-1:0] top_q, dest_phys;
  logic             push_ov, push_un, pop_un, fault, commit, is_pop;
  fpstk_stat_t      stat_q;

  assign is_pop     = (op_i == OP_POP);
  assign dest_phys  = top_q - 1'b1;
  assign src_phys_o = top_q + src_idx_i;

  // source tag sampled against the old top, before the decrement
  assign push_ov = tags_i[dest_phys];
  assign push_un = src_reg_i && !tags_i[src_phys_o];
  assign pop_un  = !tags_i[top_q];
  assign fault   = is_pop ? pop_un : (push_ov || push_un);
  assign commit  = accept_i && (!fault || ia_mask_i);

  assign wr_en_o   = commit && !is_pop;
  assign wr_idx_o  = dest_phys;
  assign wr_data_o = fault ? INDEF : (src_reg_i ? src_data_i : load_data_i);
  assign clr_en_o  = commit && is_pop;
  assign clr_idx_o = top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     top_q <= '0;
    else if (commit) top_q <= is_pop ? top_q + 1'b1 : dest_phys;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (accept_i) begin
      stat_q.c1    <= !is_pop && push_ov;
      stat_q.fault <= fault;
    end
  end

  assign top_o  = top_q;
  assign stat_o = stat_q;

  a_r2_top_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> top_q == $past(top_q) - 1'b1);
  a_r2_st0_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> tags_i[top_q]);
  a_r4_c1_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !is_pop && tags_i[top_q - 1'b1] |=> stat_q.c1 && stat_q.fault);
  a_r6_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !is_pop && src_reg_i && !tags_i[src_phys_o] |=> stat_q.fault);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && fault && !ia_mask_i |=> $stable(top_q) && $stable(tags_i));
  a_r9_pop_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_o |=> top_q == $past(top_q) + 1'b1 && !stat_q.c1);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(top_q) && $stable(stat_q) && $stable(tags_i));
endmodule

// File: rtl/fpstk_unit.sv
module fpstk_unit
  import fpstk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_pop_i,
  input  logic              cmd_src_reg_i,
  input  logic [PTR_W-1:0]  cmd_src_idx_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              ia_mask_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [PTR_W-1:0]  top_o,
  output logic              c1_o,
  output logic              stack_fault_o
);
  logic              ready_q, accept;
  logic              wr_en, clr_en;
  logic [PTR_W-1:0]  wr_idx, clr_idx, src_phys, rd_phys;
  logic [DATA_W-1:0] wr_data, src_data;
  logic [DEPTH-1:0]  tags;
  fpstk_stat_t       stat;
  fpstk_op_e         op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign cmd_ready_o = ready_q;
  assign accept      = cmd_valid_i && ready_q;
  assign op          = cmd_pop_i ? OP_POP : OP_PUSH;

  fpstk_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .EXP_W(EXP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .op_i        (op),
    .src_reg_i   (cmd_src_reg_i),
    .src_idx_i   (cmd_src_idx_i),
    .load_data_i (cmd_data_i),
    .ia_mask_i   (ia_mask_i),
    .tags_i      (tags),
    .src_data_i  (src_data),
    .top_o       (top_o),
    .src_phys_o  (src_phys),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .clr_en_o    (clr_en),
    .clr_idx_o   (clr_idx),
    .stat_o      (stat)
  );

  assign rd_phys = top_o + rd_idx_i;

  fpstk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .clr_en_i  (clr_en),
    .clr_idx_i (clr_idx),
    .ra_idx_i  (src_phys),
    .ra_data_o (src_data),
    .rb_idx_i  (rd_phys),
    .rb_data_o (rd_data_o),
    .tags_o    (tags)
  );

  assign rd_valid_o    = tags[rd_phys];
  assign c1_o          = stat.c1;
  assign stack_fault_o = stat.fault;

  // R1: ready rises only after reset is released
  a_r1_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> cmd_ready_o);
endmodule

// File: tb/fpstk_unit_test.sv
`timescale 1ns/100ps
module fpstk_unit_test;
  localparam int N = 8;
  localparam logic [79:0] INDEF = {1'b1, 15'h7fff, 64'hC000_0000_0000_0000};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, pop = 1'b0, src_reg = 1'b0, mask = 1'b0;
  logic [2:0]  src_idx = '0, rd_idx = '0;
  logic [79:0] data = '0;
  logic        ready, rd_valid, c1, fault;
  logic [79:0] rd_data;
  logic [2:0]  top;

  logic [79:0] m_data [N];
  logic [N-1:0] m_tag;
  logic [2:0]  m_top;
  logic        m_c1, m_fault;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpstk_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_pop_i(pop), .cmd_src_reg_i(src_reg), .cmd_src_idx_i(src_idx),
    .cmd_data_i(data), .ia_mask_i(mask), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .top_o(top), .c1_o(c1), .stack_fault_o(fault)
  );

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "top", 80'(top), 80'(m_top));
    chk(req, "c1", 80'(c1), 80'(m_c1));
    chk(req, "fault", 80'(fault), 80'(m_fault));
    for (int i = 0; i < N; i++) begin
      logic [2:0] p;
      p = m_top + 3'(i);
      rd_idx = 3'(i);
      #0.1;
      chk(req, $sformatf("tag ST%0d", i), 80'(rd_valid), 80'(m_tag[p]));
      if (m_tag[p]) chk(req, $sformatf("data ST%0d", i), rd_data, m_data[p]);
    end
  endtask

  // reference model applied before the accepting edge; returns requirement tag
  function automatic string model(input logic p_pop, input logic p_reg, input logic [2:0] idx,
                                  input logic [79:0] d, input logic msk);
    logic [2:0] dst, src;
    logic ov, un, flt;
    logic [79:0] val;
    string r;
    if (p_pop) begin
      flt = !m_tag[m_top];
      m_c1 = 1'b0; m_fault = flt;
      r = flt ? (msk ? "R9" : "R8") : "R9";
      if (!flt || msk) begin m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
      return r;
    end
    dst = m_top - 3'd1;
    src = m_top + idx;
    ov  = m_tag[dst];
    un  = p_reg && !m_tag[src];
    flt = ov || un;
    val = flt ? INDEF : (p_reg ? m_data[src] : d);
    m_c1 = ov; m_fault = flt;
    if (!flt)      r = p_reg ? "R3" : "R2";
    else if (!msk) r = "R8";
    else           r = ov ? "R4" : "R6";
    if (!flt || msk) begin m_data[dst] = val; m_tag[dst] = 1'b1; m_top = dst; end
    if (flt && msk && !ov) r = "R7";
    return r;
  endfunction

  task automatic cmd(input logic p_pop, input logic p_reg, input logic [2:0] idx,
                     input logic [79:0] d, input logic msk);
    string r;
    valid = 1'b1; pop = p_pop; src_reg = p_reg; src_idx = idx; data = d; mask = msk;
    r = model(p_pop, p_reg, idx, d, msk);
    @(posedge clk); @(negedge clk);
    valid = 1'b0;
    check_all(r);
  endtask

  task automatic idle(input logic [79:0] d);
    valid = 1'b0; pop = d[0]; src_reg = d[1]; src_idx = d[4:2]; data = d; mask = d[5];
    @(posedge clk); @(negedge clk);
    check_all("R10");
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    m_tag = '0; m_top = '0; m_c1 = 0; m_fault = 0;
    for (int i = 0; i < N; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "ready", 80'(ready), 80'(1));
    check_all("R1");

    // R2 push external, R3 duplicate ST(0), R5 C1 clear
    cmd(0, 0, 0, 80'h4000_8000_0000_0000_0000, 1);
    chk("R5", "c1 clear", 80'(c1), 80'(0));
    cmd(0, 1, 0, '0, 1);
    chk("R3", "dup ST1", 80'(rd_data), 80'h0); // rd_idx left at 7, just a touch
    rd_idx = 3'd1; #0.1;
    chk("R3", "ST1 value", rd_data, 80'h4000_8000_0000_0000_0000);
    // R6 underflow unmasked then masked (R8, R7)
    cmd(0, 1, 5, '0, 0);
    cmd(0, 1, 5, '0, 1);
    rd_idx = 3'd0; #0.1;
    chk("R7", "indef", rd_data, INDEF);
    // fill to overflow: R4 unmasked and masked
    for (int i = 0; i < 6; i++) cmd(0, 0, 0, rnd80(), 1);
    cmd(0, 0, 0, rnd80(), 0);
    chk("R4", "c1 ovf", 80'(c1), 80'(1));
    cmd(0, 1, 7, '0, 1);
    // drain and pop empty: R9
    for (int i = 0; i < 9; i++) cmd(1, 0, 0, '0, 1);
    cmd(1, 0, 0, '0, 0);
    idle(rnd80());

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) idle(rnd80());
      else cmd(r[6:4] < 3, r[7], 3'(r[10:8]), rnd80(), r[12:11] != 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule